// File: doc/BRIEF.md
# Bidirectional Halfword Shift Staging Buffer

This block is a small register-mapped staging buffer for 16-bit line data that moves between a processor bus and a compression/decompression engine. It has five 16-bit registers arranged as one shift chain. The first is the data port. The other four are queue stages Q1 to Q4. Software reaches the data port one byte at a time and can read every queue stage. It advances the chain by writing anything to a transfer strobe location.

The direction of each shift comes from the engine's flow mode. In drain mode the engine is emptying the buffer, and values walk from the port towards Q4; whatever sat in Q4 falls off the end. In fill mode the engine is filling the buffer, and values walk from Q4 towards the port, leaving Q4 with a value that carries no meaning. The engine side has its own shift request, which shares the same shift logic. It also has a full-width port write and a continuous view of the port.

Top module: `line_stage_fifo`

## Requirements
- R1: A bus write to byte address 2 or 3 (the transfer strobe) advances the chain by exactly one position whatever the written data; the strobe stores nothing.
- R2: In drain mode (cdc_mode = 0) one shift loads Q1 from the port, Q2 from Q1, Q3 from Q2 and Q4 from Q3 in the same cycle, and the port keeps its value.
- R3: In drain mode the old Q4 content is lost on each shift, replaced by the old Q3 content.
- R4: In fill mode (cdc_mode = 1) one shift loads the port from Q1, Q1 from Q2, Q2 from Q3 and Q3 from Q4 in the same cycle; Q4 afterwards holds a don't-care value.
- R5: A bus write to byte address 0 sets port bits 7:0 and to address 1 sets port bits 15:8, leaving the other byte unchanged.
- R6: A bus read returns on bus_rdata, one cycle after bus_rd, the byte at bus_addr: 0/1 port low/high, 4+2(k-1) and 5+2(k-1) queue stage Qk low/high for k = 1..4; reads of addresses 2 and 3 return a don't-care value.
- R7: The direction of a shift is the value of cdc_mode in the cycle of the strobe or request.
- R8: cdc_shift_req causes one shift through the same logic; a bus strobe and a codec request in the same cycle give only one shift.
- R9: A port write in the same cycle as a shift wins over the value shifted into the port; when a codec port write and a bus byte write coincide, the bus byte wins in its lane and the codec data fills the other lane.
- R10: A synchronous active-high reset clears bus_rdata to zero; the port and queue stages keep no reset value.
- R11: cdc_port_rdata shows the current port contents at all times, one cycle after any change to the port.
- R12: In a cycle without strobe or codec request, all four queue stages hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus byte write enable |
| bus_rd | input | 1 | Bus byte read enable |
| bus_addr | input | 4 | Byte address within the block |
| bus_wdata | input | 8 | Bus write byte |
| bus_rdata | output | 8 | Registered bus read byte |
| cdc_mode | input | 1 | Flow mode: 0 drain, 1 fill |
| cdc_shift_req | input | 1 | Codec request to advance the chain |
| cdc_port_wr | input | 1 | Codec full-width port write |
| cdc_port_wdata | input | 16 | Codec port write data |
| cdc_port_rdata | output | 16 | Current port contents |

## Verification
The bench writes distinct halfwords into all five stages. It then checks that a single strobe moves every stage by exactly one position. A chain that shifted in two steps would show a duplicated or skipped value, and the wrong direction would show reversed data. It drives a bus strobe and a codec request together and expects one shift, not two. It also overlaps port writes with shifts, which catches a design that lets the shifted-in value win or clobbers the unaddressed byte lane. Random mixes of strobes, requests, mode flips and byte writes are checked against a bench model that treats the fill-mode tail as don't-care.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  localparam int LANE_BITS = 8;

  typedef enum logic {
    FLOW_DRAIN = 1'b0,
    FLOW_FILL  = 1'b1
  } flow_e;
endpackage

// File: rtl/lsf_decode.sv
module lsf_decode #(
  parameter int LANES  = 2,
  parameter int ADDR_W = 4
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  lane_we,
  output logic              strobe_hit
);
  localparam logic [ADDR_W-1:0] STROBE_LO = ADDR_W'(LANES);
  localparam logic [ADDR_W-1:0] STROBE_HI = ADDR_W'(2 * LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = bus_wr && (bus_addr == ADDR_W'(g));
  end

  // Any write landing in the strobe window is a pure shift command.
  assign strobe_hit = bus_wr && (bus_addr >= STROBE_LO) && (bus_addr < STROBE_HI);

  always_comb begin
    assert_strobe_not_lane_R1: assert (!(strobe_hit && (|lane_we)));
    assert_one_lane_R5: assert ($onehot0(lane_we));
  end
endmodule

// File: rtl/lsf_chain.sv
module lsf_chain
  import lsf_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              DEPTH    = 4,
  parameter int              LANE_W   = 8,
  parameter logic [DATA_W-1:0] FILL_VAL = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift,
  input  logic                    mode,
  input  logic [DATA_W/LANE_W-1:0] lane_we,
  input  logic [LANE_W-1:0]       lane_data,
  input  logic                    cdc_wr,
  input  logic [DATA_W-1:0]       cdc_wdata,
  output logic [DATA_W-1:0]       port_q,
  output logic [DEPTH*DATA_W-1:0] queue_q
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] port_r;
  logic [DATA_W-1:0] port_nxt;
  logic [DATA_W-1:0] q        [1:DEPTH];
  logic [DATA_W-1:0] from_up  [1:DEPTH];
  logic [DATA_W-1:0] from_dn  [1:DEPTH];
  flow_e             flow;

  assign flow = flow_e'(mode);

  // Neighbour selection for each queue stage.
  for (genvar i = 1; i <= DEPTH; i++) begin : g_src
    if (i == 1) begin : g_head
      assign from_dn[i] = port_r;
    end else begin : g_mid
      assign from_dn[i] = q[i-1];
    end
    if (i == DEPTH) begin : g_tail
      assign from_up[i] = FILL_VAL;
    end else begin : g_body
      assign from_up[i] = q[i+1];
    end
    assign queue_q[(i-1)*DATA_W +: DATA_W] = q[i];
  end

  always_ff @(posedge clk) begin
    if (shift) begin
      for (int i = 1; i <= DEPTH; i++) begin
        q[i] <= (flow == FLOW_FILL) ? from_up[i] : from_dn[i];
      end
    end
  end

  // Port: shifted value, then codec write, then bus byte lanes on top.
  always_comb begin
    port_nxt = port_r;
    if (shift && (flow == FLOW_FILL)) port_nxt = q[1];
    if (cdc_wr) port_nxt = cdc_wdata;
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) port_nxt[l*LANE_W +: LANE_W] = lane_data;
    end
  end

  always_ff @(posedge clk) begin
    port_r <= port_nxt;
  end

  assign port_q = port_r;

  assert_drain_head_R2: assert property (@(posedge clk) disable iff (rst)
    (shift && !mode) |=> (q[1] == $past(port_r)));
  assert_drain_port_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (shift && !mode && !cdc_wr && !(|lane_we)) |=> $stable(port_r));
  assert_drain_tail_R3: assert property (@(posedge clk) disable iff (rst)
    (shift && !mode) |=> (q[DEPTH] == $past(q[DEPTH-1])));
  assert_fill_port_R4: assert property (@(posedge clk) disable iff (rst)
    (shift && mode && !cdc_wr && !(|lane_we)) |=> (port_r == $past(q[1])));
  assert_fill_next_R4: assert property (@(posedge clk) disable iff (rst)
    (shift && mode) |=> (q[1] == $past(q[2])));
  assert_codec_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (cdc_wr && !(|lane_we)) |=> (port_r == $past(cdc_wdata)));
  assert_lane0_R5: assert property (@(posedge clk) disable iff (rst)
    lane_we[0] |=> (port_r[LANE_W-1:0] == $past(lane_data)));
  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !shift |=> (q[1] == $past(q[1]) && q[DEPTH] == $past(q[DEPTH])));
endmodule

// File: rtl/lsf_readback.sv
module lsf_readback #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       port_q,
  input  logic [DEPTH*DATA_W-1:0] queue_q,
  output logic [LANE_W-1:0]       rdata
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int NB    = (2 + DEPTH) * LANES;

  logic [LANE_W-1:0] view [NB];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign view[l]         = port_q[l*LANE_W +: LANE_W];
    assign view[LANES + l] = '0;
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      assign view[2*LANES + k*LANES + l] = queue_q[k*DATA_W + l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= (addr < ADDR_W'(NB)) ? view[addr] : '0;
    end
  end

  assert_rst_clear_R10: assert property (@(posedge clk) rst |=> (rdata == '0));
  assert_port_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == '0) |=> (rdata == $past(port_q[LANE_W-1:0])));
  assert_read_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/line_stage_fifo.sv
module line_stage_fifo
  import lsf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int LANE_W = LANE_BITS,
  parameter int ADDR_W = $clog2((2 + DEPTH) * (DATA_W / LANE_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANE_W-1:0] bus_wdata,
  output logic [LANE_W-1:0] bus_rdata,
  input  logic              cdc_mode,
  input  logic              cdc_shift_req,
  input  logic              cdc_port_wr,
  input  logic [DATA_W-1:0] cdc_port_wdata,
  output logic [DATA_W-1:0] cdc_port_rdata
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0]        lane_we;
  logic                    strobe_hit;
  logic                    shift;
  logic [DATA_W-1:0]       port_q;
  logic [DEPTH*DATA_W-1:0] queue_q;

  lsf_decode #(.LANES(LANES), .ADDR_W(ADDR_W)) u_decode (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .lane_we    (lane_we),
    .strobe_hit (strobe_hit)
  );

  // Bus strobe and codec request merge into a single shift.
  assign shift = strobe_hit | cdc_shift_req;

  lsf_chain #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANE_W(LANE_W)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .shift     (shift),
    .mode      (cdc_mode),
    .lane_we   (lane_we),
    .lane_data (bus_wdata),
    .cdc_wr    (cdc_port_wr),
    .cdc_wdata (cdc_port_wdata),
    .port_q    (port_q),
    .queue_q   (queue_q)
  );

  lsf_readback #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_readback (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd),
    .addr    (bus_addr),
    .port_q  (port_q),
    .queue_q (queue_q),
    .rdata   (bus_rdata)
  );

  assign cdc_port_rdata = port_q;

  assert_single_shift_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe_hit && cdc_shift_req && !cdc_mode) |=> (queue_q[DATA_W +: DATA_W] == $past(queue_q[0 +: DATA_W])));
  assert_port_view_R11: assert property (@(posedge clk) disable iff (rst)
    (!shift && !cdc_port_wr && !bus_wr) |=> $stable(cdc_port_rdata));
endmodule

// File: tb/line_stage_fifo_bench.sv
`timescale 1ns/1ps
module line_stage_fifo_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        cdc_mode, cdc_shift_req, cdc_port_wr;
  logic [15:0] cdc_port_wdata, cdc_port_rdata;

  always #4 clk = ~clk;

  line_stage_fifo u_line_stage_fifo (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cdc_mode(cdc_mode),
    .cdc_shift_req(cdc_shift_req), .cdc_port_wr(cdc_port_wr),
    .cdc_port_wdata(cdc_port_wdata), .cdc_port_rdata(cdc_port_rdata)
  );

  int total = 0;
  int bad   = 0;

  // Model: index 0 is the port, 1..4 the queue stages; vmask marks defined bytes.
  logic [15:0] m_val [0:4];
  logic [1:0]  m_vld [0:4];

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic is_strobe(input logic wr, input logic [3:0] a);
    return wr && (a == 4'd2 || a == 4'd3);
  endfunction

  task automatic model_step(input logic bwr, input logic [3:0] ba, input logic [7:0] bd,
                            input logic creq, input logic md, input logic cwr, input logic [15:0] cd);
    logic [15:0] v [0:4];
    logic [1:0]  f [0:4];
    for (int i = 0; i <= 4; i++) begin v[i] = m_val[i]; f[i] = m_vld[i]; end
    if (is_strobe(bwr, ba) || creq) begin
      if (!md) begin
        for (int i = 1; i <= 4; i++) begin v[i] = m_val[i-1]; f[i] = m_vld[i-1]; end
      end else begin
        for (int i = 0; i <= 3; i++) begin v[i] = m_val[i+1]; f[i] = m_vld[i+1]; end
        f[4] = 2'b00;
      end
    end
    if (cwr) begin v[0] = cd; f[0] = 2'b11; end
    if (bwr && ba == 4'd0) begin v[0][7:0]  = bd; f[0][0] = 1'b1; end
    if (bwr && ba == 4'd1) begin v[0][15:8] = bd; f[0][1] = 1'b1; end
    for (int i = 0; i <= 4; i++) begin m_val[i] = v[i]; m_vld[i] = f[i]; end
  endtask

  task automatic step(input logic bwr, input logic [3:0] ba, input logic [7:0] bd,
                      input logic creq, input logic md, input logic cwr, input logic [15:0] cd);
    @(negedge clk);
    bus_wr = bwr; bus_addr = ba; bus_wdata = bd;
    cdc_shift_req = creq; cdc_mode = md; cdc_port_wr = cwr; cdc_port_wdata = cd;
    model_step(bwr, ba, bd, creq, md, cwr, cd);
    @(posedge clk); #1;
    bus_wr = 1'b0; cdc_shift_req = 1'b0; cdc_port_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] b;
    int s, l;
    for (int a = 0; a < 12; a++) begin
      if (a == 2 || a == 3) continue;
      s = (a < 2) ? 0 : (a - 4) / 2 + 1;
      l = a % 2;
      rd(4'(a), b);
      if (m_vld[s][l]) chk($sformatf("%s R6 addr%0d", tag, a), {8'h00, b}, {8'h00, m_val[s][l*8 +: 8]});
    end
    @(negedge clk);
    if (m_vld[0] == 2'b11) chk({tag, " R11 codec view"}, cdc_port_rdata, m_val[0]);
  endtask

  task automatic load_all(input logic [15:0] base);
    for (int k = 4; k >= 1; k--) begin
      step(1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, base + 16'(k));
      step(1'b1, 4'd2, 8'h5A, 1'b0, 1'b0, 1'b0, 16'h0);
    end
    step(1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, base);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [31:0] r;
    void'($urandom(32'd20240611));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    cdc_mode = 0; cdc_shift_req = 0; cdc_port_wr = 0; cdc_port_wdata = 0;
    for (int i = 0; i <= 4; i++) begin m_val[i] = '0; m_vld[i] = 2'b00; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset rdata", {8'h00, bus_rdata}, 16'h0000);
    rst = 1'b0;

    // R5: byte lanes
    step(1'b1, 4'd0, 8'h34, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1'b1, 4'd1, 8'h12, 1'b0, 1'b0, 1'b0, 16'h0);
    check_all("R5 lanes");
    step(1'b1, 4'd1, 8'hAB, 1'b0, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    chk("R5 high lane only", cdc_port_rdata, 16'hAB34);

    // R2/R3: fill via drain, then one more drain drops Q4
    load_all(16'h1100);
    check_all("R2 drain chain");
    step(1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hBEEF);
    step(1'b1, 4'd3, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0);
    check_all("R3 drain discards Q4");

    // R1: strobe data ignored, one shift each
    step(1'b1, 4'd2, 8'hFF, 1'b0, 1'b0, 1'b0, 16'h0);
    check_all("R1 strobe FF");

    // R4/R7: fill shift
    load_all(16'h2200);
    step(1'b1, 4'd2, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0);
    check_all("R4 fill shift");
    step(1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 16'h0);
    step(1'b1, 4'd3, 8'h77, 1'b0, 1'b0, 1'b0, 16'h0);
    check_all("R7 mode per strobe");

    // R8: coincident strobe and request
    load_all(16'h3300);
    step(1'b1, 4'd2, 8'h01, 1'b1, 1'b0, 1'b0, 16'h0);
    check_all("R8 drain one shift");
    step(1'b1, 4'd3, 8'h02, 1'b1, 1'b1, 1'b0, 16'h0);
    check_all("R8 fill one shift");

    // R9: write during shift wins, bus lane over codec
    step(1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b1, 16'hC0DE);
    @(negedge clk);
    chk("R9 codec write over fill", cdc_port_rdata, 16'hC0DE);
    step(1'b1, 4'd1, 8'h9A, 1'b1, 1'b1, 1'b1, 16'h5566);
    @(negedge clk);
    chk("R9 bus lane over codec", cdc_port_rdata, 16'h9A66);
    check_all("R9 after overlap");

    // R12: reads and port writes without shift leave the queue alone
    step(1'b1, 4'd0, 8'hEE, 1'b0, 1'b1, 1'b0, 16'h0);
    repeat (5) @(negedge clk);
    check_all("R12 hold");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      r = $urandom;
      case (r[2:0])
        3'd0: step(1'b1, {3'b001, r[3]}, r[15:8], 1'b0, r[4], 1'b0, 16'h0);
        3'd1: step(1'b0, 4'd0, 8'h00, 1'b1, r[4], 1'b0, 16'h0);
        3'd2: step(1'b1, {3'b000, r[3]}, r[15:8], 1'b0, r[4], 1'b0, 16'h0);
        3'd3: step(1'b0, 4'd0, 8'h00, 1'b0, r[4], 1'b1, r[31:16]);
        3'd4: step(1'b1, {2'b00, r[5], r[3]}, r[15:8], r[6], r[4], r[7], r[31:16]);
        default: @(negedge clk);
      endcase
      if (n % 20 == 19) check_all("R1/R2/R4 random");
    end
    check_all("R12 random end");

    rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk("R10 reset again", {8'h00, bus_rdata}, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule